// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block watches the command pins of a single-rank SDRAM bus and reports every command that breaks a minimum clock spacing or arrives while the addressed bank is in the wrong state. It decodes chip select, row strobe, column strobe and write enable on each rising clock edge, keeps an open/closed state and a set of elapsed-cycle counters for each of the four banks, and compares each new command against the spacing rules that apply to it. The block only observes; it never drives the bus and does not model data or analog timing.

The per-bank spacings (activate to column, precharge to activate, activate to precharge, activate to activate) and the burst length arrive as input cycle counts, so one instance covers any speed grade and latency setting. The cross-bank activate spacing, the write recovery time and the lockout after a mode register set are parameters. Each rule has its own bit: a one-cycle pulse for the command that broke it, and a sticky copy that holds until reset.

Top module: `sdram_cmd_timing_checker`

## Requirements
- R1: The command is decoded from {cs_n, ras_n, cas_n, we_n}: cs_n high or ras/cas/we = 111 is no-operation, 000 mode set, 001 refresh, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge; a no-operation never raises any rule bit.
- R2: Rule bits are bit 0 activate-to-column, bit 1 precharge-to-activate, bit 2 activate-to-precharge, bit 3 same-bank activate-to-activate, bit 4 cross-bank activate spacing, bit 5 write recovery, bit 6 mode-set lockout, bit 7 auto-precharge burst conflict, bit 8 illegal state. viol_pulse shows the result for the command sampled at the previous edge; viol_sticky is the OR of all pulses since reset; reset clears both.
- R3: A read or write to an open bank fewer than t_rcd edges after its activate sets bit 0.
- R4: An activate fewer than t_rp edges after that bank was closed (by precharge or by the end of an auto-precharge burst) sets bit 1.
- R5: A precharge that closes an open bank fewer than t_ras edges after its activate sets bit 2.
- R6: An activate fewer than t_rc edges after the previous activate of the same bank sets bit 3.
- R7: An activate to a bank (address 00 to 11) different from the last activated bank, fewer than 2 edges after that activate, sets bit 4.
- R8: A precharge of an open bank that was written at edge w needs at least burst_len+1 edges after w (2 edges after the last data beat); if any read, write or burst stop at edge c ends the write burst early, the precharge needs only edge c+1 or later; earlier sets bit 5.
- R9: Any command other than no-operation fewer than 2 edges after a mode set sets bit 6.
- R10: A precharge with a10 high closes every open bank and ignores the bank address; with a10 low it closes only the addressed bank.
- R11: A read or write with a10 high to an open bank starts an auto-precharge burst; another read or write to that bank fewer than burst_len edges later sets bit 7; the bank closes at the burst's last beat (edge c+burst_len-1) and the precharge spacing of R4 counts from there.
- R12: A read or write to a closed bank, an activate to an open bank, or a mode set or refresh while any bank is open sets bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, commands sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_addr | input | 2 | Bank address |
| a10 | input | 1 | Address bit 10: all-bank precharge or auto-precharge |
| t_rcd | input | 9 | Activate to column spacing in clocks |
| t_rp | input | 9 | Close to activate spacing in clocks |
| t_ras | input | 9 | Activate to precharge spacing in clocks |
| t_rc | input | 9 | Same-bank activate spacing in clocks |
| burst_len | input | 9 | Burst length in beats, at least 1 |
| viol_pulse | output | 9 | Per-rule violation pulse, one cycle |
| viol_sticky | output | 9 | Per-rule sticky violation flags |

## Verification
The bench aims at exact boundaries: a precharge exactly t_ras after activate and a write-recovery precharge exactly burst_len+1 edges after the write must pass, while one edge less must flag, so an off-by-one counter shows up as a false alarm or a missed error. A burst stop after a write checks the early-ended burst; a checker that ignored truncation would flag the following precharge. A precharge with a10 high and bank address 0 is followed by reads to banks 1 and 3, which a design honouring the bank address would wrongly accept. The auto-precharge burst is followed by a column command and an early activate, which catch a bank that never closes or closes at the wrong edge.

// File: rtl/sdct_pkg.sv
// Shared types for the SDRAM command timing checker: the decoded command
// and the bit position of each rule in the violation vectors.
package sdct_pkg;

    typedef enum logic [2:0] {
        C_NOP = 3'd0,
        C_MRS = 3'd1,
        C_REF = 3'd2,
        C_ACT = 3'd3,
        C_RD  = 3'd4,
        C_WR  = 3'd5,
        C_BST = 3'd6,
        C_PRE = 3'd7
    } cmd_e;

    localparam int NRULE      = 9;
    localparam int RULE_RCD   = 0;
    localparam int RULE_RP    = 1;
    localparam int RULE_RAS   = 2;
    localparam int RULE_RC    = 3;
    localparam int RULE_RRD   = 4;
    localparam int RULE_WR    = 5;
    localparam int RULE_MRD   = 6;
    localparam int RULE_AP    = 7;
    localparam int RULE_STATE = 8;

endpackage

// File: rtl/sdct_decode.sv
// Command decoder. Turns the four active-low strobes into one command code.
// Assumes the strobes are already synchronous to clk; purely combinational.
module sdct_decode
    import sdct_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Map the strobe pattern to a command; deselect means no-operation.
    always_comb begin
        if (cs_n) begin
            cmd = C_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = C_MRS;
                3'b001:  cmd = C_REF;
                3'b011:  cmd = C_ACT;
                3'b101:  cmd = C_RD;
                3'b100:  cmd = C_WR;
                3'b110:  cmd = C_BST;
                3'b010:  cmd = C_PRE;
                default: cmd = C_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdct_bank.sv
// One bank tracker. Holds the open/closed state, saturating cycles-since
// counters for the last activate and the last close, a write-recovery
// countdown and an auto-precharge burst countdown. Raises the per-bank rule
// bits for the command currently on the bus. Assumes burst_len >= 1 and
// TWR >= 2; all state is updated by every command, legal or not.
module sdct_bank
    import sdct_pkg::*;
#(
    parameter int CW  = 9,
    parameter int TWR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic             sel,
    input  logic             a10,
    input  logic [CW-1:0]    t_rcd,
    input  logic [CW-1:0]    t_rp,
    input  logic [CW-1:0]    t_ras,
    input  logic [CW-1:0]    t_rc,
    input  logic [CW-1:0]    burst_len,
    output logic             is_open,
    output logic [NRULE-1:0] viol
);

    localparam int            RW      = CW + 1;
    localparam logic [CW-1:0] MAXC    = {CW{1'b1}};
    localparam logic [CW-1:0] ONE     = CW'(1);
    localparam logic [RW-1:0] REC_CUT = RW'(TWR - 2);

    logic          open_q;
    logic [CW-1:0] since_act;
    logic [CW-1:0] since_pre;
    logic [RW-1:0] rec_q;
    logic [CW-1:0] ap_q;

    logic is_act, is_col, is_pre, wr_start, ap_start, ap_end, close_now, trunc;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] x);
        return (x == MAXC) ? x : x + ONE;
    endfunction

    // Qualify the bus command for this bank and derive the state events.
    always_comb begin
        is_act    = (cmd == C_ACT) && sel;
        is_col    = ((cmd == C_RD) || (cmd == C_WR)) && sel;
        is_pre    = (cmd == C_PRE) && (sel || a10);
        trunc     = (cmd == C_RD) || (cmd == C_WR) || (cmd == C_BST);
        wr_start  = (cmd == C_WR) && sel && open_q;
        ap_start  = is_col && a10 && open_q;
        ap_end    = open_q && ((ap_q == ONE) || (ap_start && (burst_len == ONE)));
        close_now = open_q && (is_pre || ap_end);
    end

    // Evaluate this bank's spacing and state rules for the current command.
    always_comb begin
        viol             = '0;
        viol[RULE_RCD]   = is_col && open_q && (since_act < t_rcd);
        viol[RULE_RP]    = is_act && (since_pre < t_rp);
        viol[RULE_RC]    = is_act && (since_act < t_rc);
        viol[RULE_RAS]   = is_pre && open_q && (since_act < t_ras);
        viol[RULE_WR]    = is_pre && open_q && (rec_q != '0);
        viol[RULE_AP]    = is_col && (ap_q != '0);
        viol[RULE_STATE] = (is_col && !open_q) || (is_act && open_q);
    end

    // Advance bank state, elapsed counters and countdowns on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q    <= 1'b0;
            since_act <= MAXC;
            since_pre <= MAXC;
            rec_q     <= '0;
            ap_q      <= '0;
        end else begin
            since_act <= is_act ? ONE : sat_inc(since_act);
            since_pre <= close_now ? ONE : sat_inc(since_pre);

            if (is_act)
                open_q <= 1'b1;
            else if (close_now)
                open_q <= 1'b0;

            if (close_now)
                rec_q <= '0;
            else if (wr_start)
                rec_q <= RW'(burst_len) + REC_CUT;
            else if (trunc && (rec_q > REC_CUT))
                rec_q <= REC_CUT;
            else if (rec_q != '0)
                rec_q <= rec_q - RW'(1);

            if (close_now)
                ap_q <= '0;
            else if (ap_start)
                ap_q <= burst_len - ONE;
            else if (ap_q != '0)
                ap_q <= ap_q - ONE;
        end
    end

    assign is_open = open_q;

    AST_AP_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_q != '0) |-> open_q);  // R11
    AST_REC_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !open_q |-> (rec_q == '0));  // R8
    AST_AP_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && (ap_q == ONE) && (cmd != C_ACT)) |=> !open_q);  // R11

endmodule

// File: rtl/sdct_global.sv
// Cross-bank rules: activate spacing between different banks, the lockout
// after a mode set, and mode set or refresh while any bank is open.
// Assumes the bank trackers report their open state for the current cycle.
module sdct_global
    import sdct_pkg::*;
#(
    parameter int CW   = 9,
    parameter int BAW  = 2,
    parameter int TRRD = 2,
    parameter int TMRD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic [BAW-1:0]   bank_addr,
    input  logic             any_open,
    output logic [NRULE-1:0] viol
);

    localparam logic [CW-1:0] MAXC   = {CW{1'b1}};
    localparam logic [CW-1:0] ONE    = CW'(1);
    localparam logic [CW-1:0] RRD_C  = CW'(TRRD);
    localparam logic [CW-1:0] MRD_C  = CW'(TMRD);

    logic [CW-1:0]  since_any;
    logic [CW-1:0]  since_mrs;
    logic [BAW-1:0] last_bank;

    // Evaluate the cross-bank and mode-set rules for the current command.
    always_comb begin
        viol             = '0;
        viol[RULE_RRD]   = (cmd == C_ACT) && (bank_addr != last_bank) && (since_any < RRD_C);
        viol[RULE_MRD]   = (cmd != C_NOP) && (since_mrs < MRD_C);
        viol[RULE_STATE] = ((cmd == C_MRS) || (cmd == C_REF)) && any_open;
    end

    // Track the last activate (any bank) and the last mode set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_any <= MAXC;
            since_mrs <= MAXC;
            last_bank <= '0;
        end else begin
            if (cmd == C_ACT) begin
                since_any <= ONE;
                last_bank <= bank_addr;
            end else if (since_any != MAXC) begin
                since_any <= since_any + ONE;
            end
            if (cmd == C_MRS)
                since_mrs <= ONE;
            else if (since_mrs != MAXC)
                since_mrs <= since_mrs + ONE;
        end
    end

    AST_MRD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((TMRD > 1) && $past(cmd == C_MRS) && (cmd != C_NOP)) |-> viol[RULE_MRD]);  // R9

endmodule

// File: rtl/sdram_cmd_timing_checker.sv
// SDRAM command timing checker, top level. Decodes the command bus, runs one
// tracker per bank plus the cross-bank rules, merges their rule bits and
// registers them as a one-cycle pulse vector and a sticky vector.
// Assumes one command per clock on the bus and burst_len >= 1.
module sdram_cmd_timing_checker
    import sdct_pkg::*;
#(
    parameter int CW    = 9,
    parameter int NBANK = 4,
    parameter int BAW   = $clog2(NBANK),
    parameter int TWR   = 2,
    parameter int TRRD  = 2,
    parameter int TMRD  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [BAW-1:0]   bank_addr,
    input  logic             a10,
    input  logic [CW-1:0]    t_rcd,
    input  logic [CW-1:0]    t_rp,
    input  logic [CW-1:0]    t_ras,
    input  logic [CW-1:0]    t_rc,
    input  logic [CW-1:0]    burst_len,
    output logic [NRULE-1:0] viol_pulse,
    output logic [NRULE-1:0] viol_sticky
);

    cmd_e             cmd;
    logic [NBANK-1:0] bank_open;
    logic [NRULE-1:0] bank_viol [NBANK];
    logic [NRULE-1:0] glob_viol;
    logic [NRULE-1:0] viol_now;

    sdct_decode i_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sdct_bank #(
            .CW  (CW),
            .TWR (TWR)
        ) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd),
            .sel       (bank_addr == BAW'(b)),
            .a10       (a10),
            .t_rcd     (t_rcd),
            .t_rp      (t_rp),
            .t_ras     (t_ras),
            .t_rc      (t_rc),
            .burst_len (burst_len),
            .is_open   (bank_open[b]),
            .viol      (bank_viol[b])
        );
    end

    sdct_global #(
        .CW   (CW),
        .BAW  (BAW),
        .TRRD (TRRD),
        .TMRD (TMRD)
    ) i_global (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .bank_addr (bank_addr),
        .any_open  (|bank_open),
        .viol      (glob_viol)
    );

    // Merge the rule bits of all banks with the cross-bank rules.
    always_comb begin
        viol_now = glob_viol;
        for (int b = 0; b < NBANK; b++)
            viol_now = viol_now | bank_viol[b];
    end

    // Register the pulse vector and accumulate the sticky vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_pulse  <= '0;
            viol_sticky <= '0;
        end else begin
            viol_pulse  <= viol_now;
            viol_sticky <= viol_sticky | viol_now;
        end
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((viol_sticky & $past(viol_sticky)) == $past(viol_sticky)));  // R2
    AST_PULSE_IN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((viol_pulse & ~viol_sticky) == '0));  // R2

endmodule

// File: tb/test_sdram_cmd_timing_checker.sv
// Scoreboard bench: the driver issues one command per clock and queues the
// rule bits it expects; the monitor compares them after the following edge.
module test_sdram_cmd_timing_checker;

    localparam logic [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_ACT = 3'b011,
                           K_RD  = 3'b101, K_WR  = 3'b100, K_BST = 3'b110,
                           K_PRE = 3'b010, K_NOP = 3'b111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] bank_addr = 2'd0;
    logic       a10 = 1'b0;
    logic [8:0] t_rcd = 9'd3, t_rp = 9'd3, t_ras = 9'd7, t_rc = 9'd10, burst_len = 9'd4;
    logic [8:0] viol_pulse, viol_sticky;

    int errors = 0;
    int checks = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    sdram_cmd_timing_checker i_sdram_cmd_timing_checker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .bank_addr(bank_addr), .a10(a10), .t_rcd(t_rcd),
        .t_rp(t_rp), .t_ras(t_ras), .t_rc(t_rc), .burst_len(burst_len),
        .viol_pulse(viol_pulse), .viol_sticky(viol_sticky)
    );

    task automatic issue(input logic cs, input logic [2:0] rcw, input logic [1:0] ba,
                         input logic ap, input logic [8:0] mask, input string tag);
        @(negedge clk);
        cs_n = cs;
        {ras_n, cas_n, we_n} = rcw;
        bank_addr = ba;
        a10 = ap;
        exp_q.push_back(mask);
        tag_q.push_back(tag);
    endtask

    task automatic cmd(input logic [2:0] rcw, input logic [1:0] ba, input logic ap,
                       input logic [8:0] mask, input string tag);
        issue(1'b0, rcw, ba, ap, mask, tag);
    endtask

    task automatic nops(input int n, input string tag);
        for (int i = 0; i < n; i++) issue(1'b1, K_NOP, 2'd0, 1'b0, 9'h000, tag);
    endtask

    task automatic chk_sticky(input logic [8:0] exp, input string tag);
        @(posedge clk);
        #3;
        checks++;
        if (viol_sticky !== exp) begin
            errors++;
            $display("FAIL %s: sticky=%03h expected=%03h", tag, viol_sticky, exp);
        end
    endtask

    task automatic chk_pulse_now(input logic [8:0] exp, input string tag);
        checks++;
        if (viol_pulse !== exp) begin
            errors++;
            $display("FAIL %s: pulse=%03h expected=%03h", tag, viol_pulse, exp);
        end
    endtask

    // Monitor: compare each queued expectation just after its edge.
    initial begin
        logic [8:0] m;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                m = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (viol_pulse !== m) begin
                    errors++;
                    $display("FAIL %s: pulse=%03h expected=%03h", t, viol_pulse, m);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Driver: the command sequence with the rule bits each command must raise.
    initial begin
        repeat (3) @(posedge clk);
        #3;
        chk_pulse_now(9'h000, "R2 reset pulse");
        chk_sticky(9'h000, "R2 reset sticky");
        @(negedge clk);
        rst_n = 1'b1;

        cmd(K_ACT, 2'd0, 1'b0, 9'h000, "R3");
        cmd(K_RD,  2'd0, 1'b0, 9'h001, "R3 early read");
        chk_sticky(9'h001, "R2 sticky after first pulse");
        nops(1, "R1 deselect");
        cmd(K_RD,  2'd0, 1'b0, 9'h000, "R3 read at t_rcd");
        cmd(K_ACT, 2'd1, 1'b0, 9'h000, "R7");
        cmd(K_ACT, 2'd1, 1'b0, 9'h108, "R6 R12 reopen");
        cmd(K_ACT, 2'd2, 1'b0, 9'h010, "R7 cross-bank");
        cmd(K_PRE, 2'd0, 1'b0, 9'h000, "R5 at t_ras");
        cmd(K_ACT, 2'd0, 1'b0, 9'h00A, "R4 R6 early activate");
        cmd(K_PRE, 2'd1, 1'b0, 9'h004, "R5 early precharge");
        cmd(K_WR,  2'd2, 1'b0, 9'h000, "R8 write");
        nops(3, "R8");
        cmd(K_PRE, 2'd2, 1'b0, 9'h020, "R8 recovery short");
        nops(12, "R1");

        cmd(K_ACT, 2'd2, 1'b0, 9'h000, "R4");
        nops(3, "R8");
        cmd(K_WR,  2'd2, 1'b0, 9'h000, "R8 write");
        nops(4, "R8");
        cmd(K_PRE, 2'd2, 1'b0, 9'h000, "R8 recovery exact");
        cmd(K_WR,  2'd0, 1'b0, 9'h000, "R8 write");
        cmd(K_BST, 2'd0, 1'b0, 9'h000, "R8 burst stop");
        cmd(K_PRE, 2'd0, 1'b0, 9'h000, "R8 truncated recovery");

        cmd(K_ACT, 2'd1, 1'b0, 9'h000, "R10");
        nops(1, "R10");
        cmd(K_ACT, 2'd3, 1'b0, 9'h000, "R7 spacing exact bank 3");
        nops(6, "R10");
        cmd(K_PRE, 2'd0, 1'b1, 9'h000, "R10 precharge all");
        cmd(K_RD,  2'd1, 1'b0, 9'h100, "R10 bank 1 closed");
        cmd(K_RD,  2'd3, 1'b0, 9'h100, "R10 bank 3 closed");
        cmd(K_ACT, 2'd1, 1'b0, 9'h000, "R4 at t_rp");
        cmd(K_PRE, 2'd2, 1'b1, 9'h004, "R10 R5 precharge all early");

        nops(3, "R9");
        cmd(K_MRS, 2'd0, 1'b0, 9'h000, "R9 mode set idle");
        cmd(K_NOP, 2'd0, 1'b0, 9'h000, "R1 strobe nop in lockout");
        cmd(K_REF, 2'd0, 1'b0, 9'h000, "R9 refresh after lockout");
        cmd(K_MRS, 2'd0, 1'b0, 9'h000, "R9");
        cmd(K_ACT, 2'd0, 1'b0, 9'h040, "R9 activate in lockout");
        cmd(K_MRS, 2'd0, 1'b0, 9'h100, "R12 mode set bank open");
        cmd(K_REF, 2'd0, 1'b0, 9'h140, "R12 R9 refresh");
        nops(3, "R11");

        cmd(K_RD,  2'd0, 1'b1, 9'h000, "R11 auto-precharge read");
        cmd(K_WR,  2'd0, 1'b0, 9'h080, "R11 column in burst");
        nops(2, "R11");
        cmd(K_RD,  2'd0, 1'b0, 9'h100, "R11 bank closed at end");
        cmd(K_ACT, 2'd0, 1'b0, 9'h002, "R11 R4 t_rp from burst end");

        chk_sticky(9'h1FF, "R2 sticky all rules");

        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #3;
        chk_pulse_now(9'h000, "R2 pulse after reset");
        chk_sticky(9'h000, "R2 sticky cleared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule